// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the integer execution unit of a load/store RISC datapath. In one cycle it combines a first operand with a second operand that the shifter has already prepared, and it produces the result, a write enable for that result, and the next values of the four condition flags. The unit does not hold any state. The caller feeds the current flags in and stores the flags that come out.

Every operation is predicated by a 4-bit condition field that is tested against the incoming flags. When the predicate is false, the operation is cancelled: the result is not written and the flags pass through unchanged. When the predicate is true, how the flags are updated depends on the operation class:

- Arithmetic operations derive carry and overflow from the adder.
- Bitwise operations take carry from the shifter and leave overflow untouched.
- Probe operations (compare, compare-negative, test, test-equivalence) update the flags and never write a result.

Top module: `dp_alu`

## Requirements
- R1: Operation select codes are AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. ADD gives a+b and ADC gives a+b+C, where C is the incoming carry flag.
- R2: SUB gives a-b and SBC gives a-b-(1-C). RSB gives b-a and RSC gives b-a-(1-C).
- R3: For add-type operations the new C is the carry out of the top bit. For subtract-type operations the new C is 1 when no borrow occurred and 0 when a borrow was needed.
- R4: Overflow is handled as follows. For add-type operations, V is set when both operands share a sign and the result sign differs from it. For subtract-type operations, V is set when the operands differ in sign and the result sign differs from that of the minuend.
- R5: The flags are packed as {N,Z,C,V} on bits 3..0. When flags are updated, N is result bit 31 and Z is 1 exactly when the result is zero.
- R6: AND, EOR and ORR give bitwise results. BIC gives a AND NOT b. MOV gives b and MVN gives NOT b; both ignore a.
- R7: AND, EOR, ORR, BIC, MOV, MVN, TST and TEQ set C from shift_carry and keep V as it came in.
- R8: TST, TEQ, CMP and CMN never assert result_we. When their condition passes, they update the flags whatever set_flags says.
- R9: All other operations write the result when their condition passes. They change the flags only when set_flags is 1; otherwise flags_out equals flags_in.
- R10: Condition codes run from 0 to 15 in this order: EQ (Z), NE (!Z), CS (C), CC (!C), MI (N), PL (!N), VS (V), VC (!V), HI (C&!Z), LS (!C|Z), GE (N==V), LT (N!=V), GT (!Z&N==V), LE (Z|N!=V), AL (always) and NV (never).
- R11: When the condition fails, result_we is 0 and flags_out equals flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select |
| cond | input | 4 | Condition predicate |
| set_flags | input | 1 | Request a flag update for non-probe operations |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second, already shifted, operand |
| shift_carry | input | 1 | Carry out of the shifter |
| flags_in | input | 4 | Current {N,Z,C,V} |
| result | output | WIDTH | Computed value |
| result_we | output | 1 | Result is to be written |
| flags_out | output | 4 | Next {N,Z,C,V} |

## Verification
The bench builds the unit with the default WIDTH of 32. This places the signed boundary between 0x7FFFFFFF and 0x80000000, and the unsigned wrap at 0xFFFFFFFF, directly in the vector table, so carry, borrow and overflow are each exercised at their exact edges. A directed sweep then runs every one of the 16 condition codes against all 16 flag combinations. This covers both the gated result write and the frozen flags for every predicate outcome.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_sel,
  input  logic [3:0]       cond,
  input  logic             set_flags,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             shift_carry,
  input  logic [3:0]       flags_in,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [3:0]       flags_out
);
  localparam int MSB = WIDTH - 1;

  typedef enum logic [3:0] {
    OP_AND, OP_EOR, OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
    OP_TST, OP_TEQ, OP_CMP, OP_CMN, OP_ORR, OP_MOV, OP_BIC, OP_MVN
  } op_e;

  op_e op;
  assign op = op_e'(op_sel);

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags_in;

  logic cond_pass;
  always_comb begin
    unique case (cond)
      4'h0: cond_pass = fz;
      4'h1: cond_pass = !fz;
      4'h2: cond_pass = fc;
      4'h3: cond_pass = !fc;
      4'h4: cond_pass = fn;
      4'h5: cond_pass = !fn;
      4'h6: cond_pass = fv;
      4'h7: cond_pass = !fv;
      4'h8: cond_pass = fc && !fz;
      4'h9: cond_pass = !fc || fz;
      4'hA: cond_pass = (fn == fv);
      4'hB: cond_pass = (fn != fv);
      4'hC: cond_pass = !fz && (fn == fv);
      4'hD: cond_pass = fz || (fn != fv);
      4'hE: cond_pass = 1'b1;
      default: cond_pass = 1'b0;
    endcase
  end

  logic [WIDTH-1:0] add_x, add_y;
  logic             add_ci, is_arith;
  always_comb begin
    add_x    = opa;
    add_y    = opb;
    add_ci   = 1'b0;
    is_arith = 1'b1;
    unique case (op)
      OP_ADD, OP_CMN: ;
      OP_ADC:         add_ci = fc;
      OP_SUB, OP_CMP: begin add_y = ~opb; add_ci = 1'b1; end
      OP_SBC:         begin add_y = ~opb; add_ci = fc;   end
      OP_RSB:         begin add_x = opb; add_y = ~opa; add_ci = 1'b1; end
      OP_RSC:         begin add_x = opb; add_y = ~opa; add_ci = fc;   end
      default:        is_arith = 1'b0;
    endcase
  end

  logic [WIDTH:0] sum;
  assign sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_ci};

  logic ovf;
  assign ovf = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);

  logic [WIDTH-1:0] logic_res;
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: logic_res = opa & opb;
      OP_EOR, OP_TEQ: logic_res = opa ^ opb;
      OP_ORR:         logic_res = opa | opb;
      OP_BIC:         logic_res = opa & ~opb;
      OP_MOV:         logic_res = opb;
      OP_MVN:         logic_res = ~opb;
      default:        logic_res = '0;
    endcase
  end

  assign result = is_arith ? sum[MSB:0] : logic_res;

  logic is_probe, upd;
  assign is_probe  = (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  assign upd       = cond_pass && (is_probe || set_flags);
  assign result_we = cond_pass && !is_probe;

  logic [3:0] new_flags;
  assign new_flags = {result[MSB], result == '0,
                      is_arith ? sum[WIDTH] : shift_carry,
                      is_arith ? ovf : fv};
  assign flags_out = upd ? new_flags : flags_in;

  always_comb begin
    if (cond == 4'hF)
      a_r10_never_passes: assert (!result_we && flags_out == flags_in);
    if (!cond_pass)
      a_r11_fail_holds: assert (!result_we && flags_out == flags_in);
    if (op_sel[3:2] == 2'b10)
      a_r8_probe_no_write: assert (!result_we);
    if (!is_arith)
      a_r7_logic_keeps_v: assert (flags_out[0] == flags_in[0]);
    if (result_we && !set_flags)
      a_r9_quiet_flags: assert (flags_out == flags_in);
    if (result_we && set_flags)
      a_r5_nz_follow: assert (flags_out[3] == result[MSB] && flags_out[2] == (result == '0));
  end
endmodule

// File: tb/dp_alu_test.sv
module dp_alu_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  op_sel = 4'h0, cond = 4'hF, flags_in = 4'h0;
  logic        set_flags = 1'b0, shift_carry = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_out;

  dp_alu #(.WIDTH(32)) uut (
    .op_sel(op_sel), .cond(cond), .set_flags(set_flags), .opa(opa), .opb(opb),
    .shift_carry(shift_carry), .flags_in(flags_in),
    .result(result), .result_we(result_we), .flags_out(flags_out));

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic [3:0]  cnd;
    logic        s;
    logic [3:0]  fin;
    logic        sc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        we;
    logic [3:0]  fout;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 4'h4, 4'hE, 1'b1, 4'h0, 1'b0, 32'd5, 32'd3, 32'd8, 1'b1, 4'h0},                         // R1 add
    '{8'd3, 4'h4, 4'hE, 1'b1, 4'h0, 1'b0, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b1, 4'h6},                  // R3 carry out, R5 Z
    '{8'd4, 4'h4, 4'hE, 1'b1, 4'h0, 1'b0, 32'h7FFFFFFF, 32'd1, 32'h80000000, 1'b1, 4'h9},           // R4 add overflow
    '{8'd9, 4'h5, 4'hE, 1'b0, 4'h2, 1'b0, 32'd5, 32'd3, 32'd9, 1'b1, 4'h2},                         // R1 adc, R9 no S
    '{8'd3, 4'h2, 4'hE, 1'b1, 4'h0, 1'b0, 32'd5, 32'd3, 32'd2, 1'b1, 4'h2},                         // R3 no borrow
    '{8'd3, 4'h2, 4'hE, 1'b1, 4'h0, 1'b0, 32'd3, 32'd5, 32'hFFFFFFFE, 1'b1, 4'h8},                  // R3 borrow
    '{8'd4, 4'h2, 4'hE, 1'b1, 4'h0, 1'b0, 32'h80000000, 32'd1, 32'h7FFFFFFF, 1'b1, 4'h3},           // R4 sub overflow
    '{8'd2, 4'h6, 4'hE, 1'b1, 4'h0, 1'b0, 32'd10, 32'd3, 32'd6, 1'b1, 4'h2},                        // R2 sbc C=0
    '{8'd2, 4'h3, 4'hE, 1'b1, 4'h0, 1'b0, 32'd3, 32'd10, 32'd7, 1'b1, 4'h2},                        // R2 rsb
    '{8'd2, 4'h7, 4'hE, 1'b1, 4'h2, 1'b0, 32'd3, 32'd10, 32'd7, 1'b1, 4'h2},                        // R2 rsc C=1
    '{8'd8, 4'hA, 4'hE, 1'b0, 4'h0, 1'b0, 32'd4, 32'd4, 32'd0, 1'b0, 4'h6},                         // R8 cmp
    '{8'd8, 4'hB, 4'hE, 1'b0, 4'h9, 1'b0, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b0, 4'h6},                  // R8 cmn
    '{8'd7, 4'h8, 4'hE, 1'b0, 4'h1, 1'b1, 32'h000000F0, 32'h0000000F, 32'd0, 1'b0, 4'h7},           // R7 tst
    '{8'd8, 4'h9, 4'hE, 1'b0, 4'h2, 1'b0, 32'h80000000, 32'd0, 32'h80000000, 1'b0, 4'h8},           // R8 teq
    '{8'd7, 4'h0, 4'hE, 1'b1, 4'h1, 1'b1, 32'hFF00FF00, 32'h0FF00FF0, 32'h0F000F00, 1'b1, 4'h3},    // R7 and
    '{8'd6, 4'h1, 4'hE, 1'b1, 4'hF, 1'b0, 32'hAAAA5555, 32'hFFFF0000, 32'h55555555, 1'b1, 4'h1},    // R6 eor
    '{8'd6, 4'hC, 4'hE, 1'b0, 4'h4, 1'b0, 32'h12340000, 32'h00005678, 32'h12345678, 1'b1, 4'h4},    // R6 orr
    '{8'd6, 4'hE, 4'hE, 1'b1, 4'h0, 1'b0, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFF0000, 1'b1, 4'h8},    // R6 bic
    '{8'd5, 4'hD, 4'hE, 1'b1, 4'h8, 1'b1, 32'hDEADBEEF, 32'd0, 32'd0, 1'b1, 4'h6},                  // R5 mov ignores a
    '{8'd6, 4'hF, 4'hE, 1'b1, 4'h1, 1'b0, 32'h12345678, 32'd0, 32'hFFFFFFFF, 1'b1, 4'h9}            // R6 mvn
  };

  function automatic bit cond_ref(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'h0: return z;          4'h1: return !z;
      4'h2: return cy;         4'h3: return !cy;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return cy && !z;   4'h9: return !cy || z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z && n == v;
      4'hD: return z || n != v;
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got res=%h we=%b fl=%h exp res=%h we=%b fl=%h",
               tag, got[36:5], got[4], got[3:0], exp[36:5], exp[4], exp[3:0]);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R10: idle inputs use NV, nothing written, flags pass through
    check("R10 idle", {result, result_we, flags_out}, {32'd0, 1'b0, 4'h0});

    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1;
      op_sel = VECS[i].op; cond = VECS[i].cnd; set_flags = VECS[i].s;
      flags_in = VECS[i].fin; shift_carry = VECS[i].sc;
      opa = VECS[i].a; opb = VECS[i].b;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), {result, result_we, flags_out},
            {VECS[i].res, VECS[i].we, VECS[i].fout});
    end

    // R10 and R11: every condition against every flag combination, ADD 1+1 with S
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        @(posedge clk); #1;
        op_sel = 4'h4; cond = 4'(c); set_flags = 1'b1; flags_in = 4'(f);
        shift_carry = 1'b1; opa = 32'd1; opb = 32'd1;
        @(negedge clk);
        if (cond_ref(4'(c), 4'(f)))
          check($sformatf("R10 c=%0d f=%0h", c, f), {result, result_we, flags_out},
                {32'd2, 1'b1, 4'h0});
        else
          check($sformatf("R11 c=%0d f=%0h", c, f), {result, result_we, flags_out},
                {32'd2, 1'b0, 4'(f)});
      end
    end

    // R8: CMP with S=0 and a failing condition leaves flags alone
    @(posedge clk); #1;
    op_sel = 4'hA; cond = 4'h0; set_flags = 1'b0; flags_in = 4'h0; opa = 32'd7; opb = 32'd7;
    @(negedge clk);
    check("R8 cmp cond fail", {result, result_we, flags_out}, {32'd0, 1'b0, 4'h0});

    // R9: ORR with S=0 leaves V and C set from input
    @(posedge clk); #1;
    op_sel = 4'hC; cond = 4'hE; flags_in = 4'h3; shift_carry = 1'b0; opa = 32'd0; opb = 32'd0;
    @(negedge clk);
    check("R9 orr no S", {result, result_we, flags_out}, {32'd0, 1'b1, 4'h3});

    // R3: SBC 0-0 with C=0 borrows to all ones, C cleared
    @(posedge clk); #1;
    op_sel = 4'h6; set_flags = 1'b1; flags_in = 4'h0;
    @(negedge clk);
    check("R3 sbc borrow", {result, result_we, flags_out}, {32'hFFFFFFFF, 1'b1, 4'h8});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule